// File: doc/BRIEF.md
# Bounded Repetition Counting Matcher

This block is one element of a hardware regular-expression engine that scans a byte stream at one byte per clock. It recognises a single-byte lead character followed by a bounded number of back-to-back copies of a fixed literal group. The lead character and the group are build-time parameters, for example lead `d` and group `abc`. The lower bound, upper bound and open-end flag are run-time inputs. One counter covers exact, at-most, at-least and range repetition without unrolling the group, however large the bounds are. An enable from the preceding regex stage qualifies the lead character, so the block chains behind earlier elements.

Bytes enter on a valid/ready interface. `in_ready` is held high at all times, so the block never applies back-pressure. A byte is accepted on every rising edge where `in_valid` is high. The result is a registered level, `match_o`. It rises after the accepted byte that completes a repetition whose new count lies inside the bounds. It stays up until the next accepted byte. Copies of the group beyond the upper bound do not extend a match, and overlapping repetitions are deliberately not tracked. The lead character must not occur inside the group.

The four repetition kinds are selected through the bounds and the flag. Exact n uses lower=upper=n with the flag clear. At-most n uses lower=1, upper=n with the flag clear. At-least n uses lower=upper=n with the flag set. Range n..m uses lower=n, upper=m with the flag clear. Bounds must satisfy 1 ≤ lower ≤ upper.

Top module: `rep_count_match`

## Requirements
- R1: After reset, `match_o` is low, the repetition count is zero and no chain is armed, so a complete group with no lead character before it gives no match.
- R2: An accepted lead byte arms a new chain only while `stage_en` is high; with `stage_en` low it arms nothing.
- R3: Each copy of the group accepted directly after an armed lead byte, or directly after the previous copy, raises the repetition count by one.
- R4: Any accepted byte that neither continues a partial copy nor completes one clears the count and ends the chain.
- R5: `match_o` goes high in the cycle after the accepted byte that completes a copy whose new count c satisfies lower ≤ c ≤ upper. It returns low after the next accepted byte unless that byte qualifies too.
- R6: With the open-end flag clear, the copy that brings the count to `hi_bound` ends the chain. Later copies give no match until a new lead byte arrives.
- R7: With the open-end flag set and lower = upper = n, the n-th copy and every further consecutive copy each raise `match_o`.
- R8: A cycle with `in_valid` low changes no state, and `match_o` holds its value.
- R9: `in_ready` is high in every cycle after reset.
- R10: The four repetition kinds, selected by the bound and flag settings above, each match exactly the counts their definition allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte is offered this cycle |
| in_ready | output | 1 | Byte acceptance; always high |
| in_data | input | 8 | Stream byte |
| stage_en | input | 1 | Preceding stage permits a lead character here |
| lo_bound | input | CNT_W | Lowest count that matches |
| hi_bound | input | CNT_W | Highest count that matches; the chain ends on reaching it |
| open_end | input | 1 | Selects at-least behaviour |
| match_o | output | 1 | Registered match level |

## Verification
The hardest state to reach from the ports is a long chain of intact copies that reaches the upper bound, or passes it in open-end mode. A uniformly random byte stream almost never produces three clean copies in a row. The stimulus therefore emits whole copies of the group as single tokens, mixed with stray letters and lead bytes, and drops `in_valid` at random. Directed sequences then aim at the exact cycle where the bound is reached and at the first byte after it.

// File: rtl/rep_count_pkg.sv
package rep_count_pkg;
  typedef logic [7:0] byte_t;

  // Extract character k of a packed literal; character 0 sits in the top byte.
  function automatic byte_t lit_char(input logic [8*16-1:0] lit, input int len, input int k);
    return lit[8*(len-1-k) +: 8];
  endfunction
endpackage

// File: rtl/rep_group_track.sv
module rep_group_track
  import rep_count_pkg::*;
#(
  parameter int          GRP_LEN = 3,
  parameter logic [8*GRP_LEN-1:0] GROUP = "abc",
  parameter byte_t       LEAD = "d"
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  byte_t data,
  input  logic  stage_en,
  input  logic  chain_go,
  output logic  done,
  output logic  extend
);
  localparam int LW = 8 * 16;

  logic [GRP_LEN-1:0] eq;
  logic               arm;
  logic               lead_hit;

  genvar k;
  generate
    for (k = 0; k < GRP_LEN; k++) begin : g_cmp
      assign eq[k] = (data == lit_char(LW'(GROUP), GRP_LEN, k));
    end
  endgenerate

  assign lead_hit = stage_en && (data == LEAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm <= 1'b0;
    else if (take) arm <= lead_hit | chain_go;
  end

  generate
    if (GRP_LEN == 1) begin : g_single
      assign done   = arm & eq[0];
      assign extend = 1'b0;
    end else begin : g_multi
      logic [GRP_LEN-2:0] part;
      logic [GRP_LEN-1:0] step;
      assign step[0] = arm & eq[0];
      for (k = 1; k < GRP_LEN; k++) begin : g_step
        assign step[k] = part[k-1] & eq[k];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) part <= '0;
        else if (take) part <= step[GRP_LEN-2:0];
      end
      assign done   = step[GRP_LEN-1];
      assign extend = |step[GRP_LEN-2:0];

      AST_PART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(arm && eq[0]) && !(|part)) |=> (part == '0)) else $error("part"); // R4
    end
  endgenerate

  AST_LEAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && stage_en && data == LEAD) |=> arm) else $error("arm"); // R2
endmodule

// File: rtl/rep_counter.sv
module rep_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             done,
  input  logic             extend,
  input  logic [CNT_W-1:0] lo_bound,
  input  logic [CNT_W-1:0] hi_bound,
  input  logic             open_end,
  output logic             chain_go,
  output logic             match,
  output logic [CNT_W-1:0] cnt
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] nxt;
  logic             at_top;
  logic             in_range;
  logic             hit;
  logic             ext_q;

  assign nxt      = {1'b0, cnt} + SUM_W'(1);
  assign at_top   = nxt >= {1'b0, hi_bound};
  assign in_range = (nxt >= {1'b0, lo_bound}) && (nxt <= {1'b0, hi_bound});
  assign hit      = done && (in_range || ext_q);
  assign chain_go = done && (open_end || !at_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ext_q <= 1'b0;
      match <= 1'b0;
    end else if (take) begin
      match <= hit;
      if (done) begin
        cnt   <= at_top ? '0 : nxt[CNT_W-1:0];
        ext_q <= ext_q | (open_end & at_top);
      end else if (!extend) begin
        cnt   <= '0;
        ext_q <= 1'b0;
      end
    end
  end

  AST_BREAK_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !done && !extend) |=> (cnt == '0)) else $error("break"); // R4
  AST_EXT_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q |-> open_end) else $error("ext"); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && done && !at_top) |=> (cnt == $past(cnt) + CNT_W'(1))) else $error("step"); // R3
endmodule

// File: rtl/rep_count_match.sv
module rep_count_match
  import rep_count_pkg::*;
#(
  parameter int    CNT_W   = 12,
  parameter int    GRP_LEN = 3,
  parameter logic [8*GRP_LEN-1:0] GROUP = "abc",
  parameter byte_t LEAD    = "d"
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             stage_en,
  input  logic [CNT_W-1:0] lo_bound,
  input  logic [CNT_W-1:0] hi_bound,
  input  logic             open_end,
  output logic             match_o
);
  localparam byte_t LAST = GROUP[7:0];

  logic             take;
  logic             done;
  logic             extend;
  logic             chain_go;
  logic [CNT_W-1:0] cnt;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  rep_group_track #(.GRP_LEN(GRP_LEN), .GROUP(GROUP), .LEAD(LEAD)) u_track (
    .clk(clk), .rst_n(rst_n), .take(take), .data(in_data), .stage_en(stage_en),
    .chain_go(chain_go), .done(done), .extend(extend)
  );

  rep_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .take(take), .done(done), .extend(extend),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .open_end(open_end),
    .chain_go(chain_go), .match(match_o), .cnt(cnt)
  );

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(match_o)) else $error("hold"); // R8
  AST_RISE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_o) |-> ($past(in_valid) && $past(in_data) == LAST)) else $error("rise"); // R5
  AST_CNT_BELOW_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt < hi_bound)) else $error("cap"); // R6
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready) else $error("ready"); // R9
endmodule

// File: tb/rep_count_match_test.sv
module rep_count_match_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [7:0] in_data = 8'h00;
  logic stage_en = 1;
  logic [CNT_W-1:0] lo_bound = 3, hi_bound = 3;
  logic open_end = 0;
  logic match_o;

  int n_checks = 0, n_fail = 0;
  // reference state
  int r_arm = 0, r_prog = 0, r_cnt = 0, r_ext = 0, r_match = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rep_count_match #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .stage_en(stage_en), .lo_bound(lo_bound),
    .hi_bound(hi_bound), .open_end(open_end), .match_o(match_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference: group "abc", lead "d", following the requirement text.
  task automatic model(input logic [7:0] b, input int en);
    int done, cont, nxt, top;
    done = (r_prog == 2 && b == "c");
    cont = (r_arm && b == "a") ? 1 : (r_prog == 1 && b == "b") ? 2 : 0;
    nxt = r_cnt + 1;
    top = (nxt >= hi_bound);
    r_match = done && ((nxt >= lo_bound && nxt <= hi_bound) || r_ext);
    r_arm = (en && b == "d") || (done && (open_end || !top));
    if (done) begin
      r_ext = r_ext | (open_end & top);
      r_cnt = top ? 0 : nxt;
    end else if (cont == 0) begin
      r_cnt = 0; r_ext = 0;
    end
    r_prog = cont;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    r_arm = 0; r_prog = 0; r_cnt = 0; r_ext = 0; r_match = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic cfg(input int lo, input int hi, input int oe);
    lo_bound = CNT_W'(lo); hi_bound = CNT_W'(hi); open_end = oe[0];
    do_reset();
  endtask

  // One cycle: drive on the falling edge, check just after the rising edge.
  task automatic cyc(input logic [7:0] b, input int v, input string tag, input int exp);
    @(negedge clk);
    in_valid = v[0]; in_data = b;
    @(posedge clk);
    #1;
    if (v != 0) model(b, stage_en);
    check({tag, " model"}, match_o, r_match);
    if (exp >= 0) check(tag, match_o, exp);
    check("R9 ready", in_ready, 1);
  endtask

  task automatic feed(input string s, input string tag, input int last_exp);
    for (int i = 0; i < s.len(); i++)
      cyc(s[i], 1, tag, (i == s.len() - 1) ? last_exp : 0);
  endtask

  task automatic sweep(input int lo, input int hi, input int oe, input string tag);
    int pend = 0;
    cfg(lo, hi, oe);
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] b;
      int r, v;
      v = ($urandom % 8) != 0;
      if (v == 0) b = "x";
      else if (pend > 0) begin b = (pend == 2) ? "b" : "c"; pend--; end
      else begin
        r = $urandom % 10;
        case (r)
          0, 1, 2, 3, 4: begin b = "a"; pend = 2; end
          5, 6: b = "d";
          7: b = "a";
          8: b = "b";
          default: b = ($urandom % 2) ? "c" : "x";
        endcase
      end
      stage_en = ($urandom % 16) != 0;
      cyc(b, v, tag, -1);
    end
    stage_en = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    cfg(3, 3, 0);
    #1;
    check("R1 reset match", match_o, 0);
    feed("abcabc", "R1 no chain after reset", 0);

    cfg(3, 3, 0);
    feed("dabcabcabc", "R3 R10 exact three", 1);
    feed("abc", "R6 beyond upper bound", 0);

    cfg(3, 3, 0);
    feed("dabcaxabcabcabc", "R4 break ends chain", 0);

    cfg(3, 3, 0);
    stage_en = 0;
    feed("dabcabcabc", "R2 lead gated off", 0);
    stage_en = 1;

    cfg(3, 3, 0);
    feed("dabcabcab", "R8 before gap", 0);
    for (int i = 0; i < 3; i++) cyc("d", 0, "R8 idle low", 0);
    cyc("c", 1, "R5 complete after gap", 1);
    for (int i = 0; i < 3; i++) cyc("x", 0, "R8 idle held", 1);
    cyc("x", 1, "R5 drop on next byte", 0);

    cfg(2, 2, 1);
    feed("dabc", "R7 first", 0);
    feed("abc", "R7 second", 1);
    feed("abc", "R7 third", 1);
    feed("abc", "R7 fourth", 1);
    cyc("x", 1, "R7 break", 0);

    cfg(2, 3, 0);
    feed("dabc", "R10 range one", 0);
    feed("abc", "R10 range two", 1);
    feed("abc", "R10 range three", 1);
    feed("abc", "R10 range four", 0);

    cfg(1, 2, 0);
    feed("dabc", "R10 at-most one", 1);
    feed("abc", "R10 at-most two", 1);
    feed("abc", "R10 at-most three", 0);

    sweep(3, 3, 0, "R10 sweep exact");
    sweep(1, 4, 0, "R10 sweep at-most");
    sweep(2, 2, 1, "R10 sweep at-least");
    sweep(2, 4, 0, "R10 sweep range");
    sweep(1, 1, 0, "R10 sweep single");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule